// File: doc/BRIEF.md
# Compare and Condition Register Unit

This block holds a condition register of eight 4-bit fields and updates at most one field per clock. A compare path checks a register operand against a second register operand or a 16-bit immediate, in signed or unsigned mode. It writes less/greater/equal flags into any field the caller selects. A record path checks an ALU result against zero and writes the outcome into field 0. It always treats the top bit of the result as a sign, whatever operation produced the result.

Every written field also carries a copy of a sticky summary-overflow flag. The ALU's overflow input sets this flag, and a dedicated clear input resets it. The written copy is the flag's value after that cycle's set and clear have been applied. Instruction decode and the ALU itself sit outside this block.

Top module: `cr_unit`

## Requirements
- R1: A signed compare treats bit 31 as a sign. Field bit 0 (LT) is set when operand A is less than operand B, bit 1 (GT) when it is greater, and bit 2 (EQ) when the two are equal. Exactly one of these bits is set.
- R2: An unsigned compare treats all 32 bits as magnitude. With A = 0 and B = 0xFFFFFFFF, the field shows LT in unsigned mode and GT in signed mode.
- R3: When the immediate is selected as operand B, it is sign-extended for signed compares and zero-extended for unsigned compares.
- R4: A compare writes field k, which occupies cr_o[4k+3:4k], for any k from 0 to 7. All other fields keep their values, and no more than one field changes per cycle.
- R5: A record writes field 0 as follows: EQ when the result is zero, LT when result bit 31 is 1, and GT when the result is non-zero and bit 31 is 0.
- R6: A record ignores the kind of operation that produced the result. A wrapped overflow sum such as 0x80000000 shows LT, and, because the overflow sets the sticky flag, it also shows SO.
- R7: Bit 3 (SO) of any written field equals the sticky flag after that cycle's update. This includes an overflow or a clear that arrives in the same cycle as the write.
- R8: The sticky flag so_o is set by ovf_i and stays set until so_clear_i is asserted. When ovf_i and so_clear_i arrive in the same cycle, the flag ends up set.
- R9: When a compare and a record arrive in the same cycle, the compare is written and the record is dropped. Field 0 keeps its value unless it is the compare's target.
- R10: Reset clears cr_o and so_o. In a cycle with no valid request, cr_o does not change.
- R11: A field update becomes visible on cr_o only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Compare request |
| cmp_signed_i | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_use_imm_i | input | 1 | 1 = use the immediate as operand B |
| cmp_field_i | input | 3 | Target field of the compare |
| cmp_a_i | input | 32 | Operand A |
| cmp_b_i | input | 32 | Register operand B |
| cmp_imm_i | input | 16 | Immediate operand B |
| rec_valid_i | input | 1 | Record request to field 0 |
| rec_result_i | input | 32 | ALU result to test against zero |
| ovf_i | input | 1 | ALU overflow; sets the sticky flag |
| so_clear_i | input | 1 | Clears the sticky flag |
| so_o | output | 1 | Sticky summary-overflow flag |
| cr_o | output | 32 | Condition register, field k at [4k+3:4k] |

## Verification
Two kinds of event can coincide in one cycle. The first is a field write together with a change to the sticky flag. The bench provokes this with a record that carries an overflow, with a compare issued alongside a clear, and with a clear and an overflow asserted together. In each case it requires the written SO bit to match the flag's post-update value. The second is a compare together with a record. The bench issues both in one cycle and requires the compare's target field to change while field 0 stays as it was.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef struct packed {
    logic so;
    logic eq;
    logic gt;
    logic lt;
  } cr_field_t;

  localparam int FIELD_W = $bits(cr_field_t);
endpackage

// File: rtl/cr_compare.sv
module cr_compare #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              signed_i,
  output logic              lt_o,
  output logic              gt_o,
  output logic              eq_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext, b_sel, a_bias, b_bias;

  always_comb begin
    imm_ext = {{EXT_W{signed_i & imm_i[IMM_W-1]}}, imm_i};
    b_sel   = use_imm_i ? imm_ext : b_i;
    // flipping the sign bit maps signed order onto unsigned order
    a_bias  = {a_i[DATA_W-1] ^ signed_i, a_i[DATA_W-2:0]};
    b_bias  = {b_sel[DATA_W-1] ^ signed_i, b_sel[DATA_W-2:0]};
    eq_o    = (a_i == b_sel);
    lt_o    = (a_bias < b_bias);
    gt_o    = ~lt_o & ~eq_o;
  end
endmodule

// File: rtl/cr_zero_test.sv
module cr_zero_test #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              lt_o,
  output logic              gt_o,
  output logic              eq_o
);
  always_comb begin
    eq_o = (res_i == '0);
    lt_o = res_i[DATA_W-1];
    gt_o = ~eq_o & ~res_i[DATA_W-1];
  end
endmodule

// File: rtl/cr_so_sticky.sv
module cr_so_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic so_next_o,
  output logic so_o
);
  logic so_q;

  // a set wins over a clear in the same cycle
  assign so_next_o = (so_q & ~clr_i) | set_i;
  assign so_o      = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) so_q <= 1'b0;
    else         so_q <= so_next_o;
  end
endmodule

// File: rtl/cr_field_file.sv
module cr_field_file
  import cr_pkg::*;
#(
  parameter int N_FIELDS = 8,
  localparam int IDX_W = $clog2(N_FIELDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  cr_field_t                  wr_data_i,
  output logic [N_FIELDS*FIELD_W-1:0] cr_o
);
  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    cr_field_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k))     q <= wr_data_i;
    end
    assign cr_o[k*FIELD_W +: FIELD_W] = q;
  end
endmodule

// File: rtl/cr_unit.sv
module cr_unit
  import cr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  parameter int N_FIELDS = 8,
  localparam int IDX_W   = $clog2(N_FIELDS),
  localparam int CR_W    = N_FIELDS * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic              cmp_signed_i,
  input  logic              cmp_use_imm_i,
  input  logic [IDX_W-1:0]  cmp_field_i,
  input  logic [DATA_W-1:0] cmp_a_i,
  input  logic [DATA_W-1:0] cmp_b_i,
  input  logic [IMM_W-1:0]  cmp_imm_i,
  input  logic              rec_valid_i,
  input  logic [DATA_W-1:0] rec_result_i,
  input  logic              ovf_i,
  input  logic              so_clear_i,
  output logic              so_o,
  output logic [CR_W-1:0]   cr_o
);
  logic cmp_lt, cmp_gt, cmp_eq;
  logic z_lt, z_gt, z_eq;
  logic so_next;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  cr_field_t wr_data;

  cr_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
    .a_i       (cmp_a_i),
    .b_i       (cmp_b_i),
    .imm_i     (cmp_imm_i),
    .use_imm_i (cmp_use_imm_i),
    .signed_i  (cmp_signed_i),
    .lt_o      (cmp_lt),
    .gt_o      (cmp_gt),
    .eq_o      (cmp_eq)
  );

  cr_zero_test #(.DATA_W(DATA_W)) u_zero (
    .res_i (rec_result_i),
    .lt_o  (z_lt),
    .gt_o  (z_gt),
    .eq_o  (z_eq)
  );

  cr_so_sticky u_so (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ovf_i),
    .clr_i     (so_clear_i),
    .so_next_o (so_next),
    .so_o      (so_o)
  );

  // compare has priority; record targets field 0
  always_comb begin
    wr_en      = cmp_valid_i | rec_valid_i;
    wr_idx     = cmp_valid_i ? cmp_field_i : '0;
    wr_data.so = so_next;
    wr_data.lt = cmp_valid_i ? cmp_lt : z_lt;
    wr_data.gt = cmp_valid_i ? cmp_gt : z_gt;
    wr_data.eq = cmp_valid_i ? cmp_eq : z_eq;
  end

  cr_field_file #(.N_FIELDS(N_FIELDS)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .cr_o      (cr_o)
  );
endmodule

// File: rtl/cr_unit_chk.sv
module cr_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int N_FIELDS = 8,
  localparam int IDX_W   = $clog2(N_FIELDS),
  localparam int CR_W    = N_FIELDS * 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_valid_i,
  input logic [IDX_W-1:0]  cmp_field_i,
  input logic              rec_valid_i,
  input logic [DATA_W-1:0] rec_result_i,
  input logic              ovf_i,
  input logic              so_clear_i,
  input logic              so_o,
  input logic [CR_W-1:0]   cr_o
);
  logic [CR_W-1:0] cr_prev;
  logic [N_FIELDS-1:0] chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cr_prev <= '0;
    else         cr_prev <= cr_o;
  end

  always_comb
    for (int k = 0; k < N_FIELDS; k++)
      chg[k] = (cr_o[k*4 +: 4] != cr_prev[k*4 +: 4]);

  // R4
  one_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i && !rec_valid_i |=> $stable(cr_o));

  // R8
  so_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> so_o);

  // R8
  so_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o && !so_clear_i |=> so_o);

  // R5
  rec_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && !cmp_valid_i |=> cr_o[2] == ($past(rec_result_i) == '0));

  // R9
  rec_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && cmp_valid_i && cmp_field_i != '0 |=> $stable(cr_o[3:0]));

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_f
    // R1
    flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(cr_o[k*4 +: 3]));
    // R7
    field_so_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_valid_i && cmp_field_i == IDX_W'(k) |=> cr_o[k*4+3] == so_o);
  end
endmodule

bind cr_unit cr_unit_chk #(.DATA_W(DATA_W), .N_FIELDS(N_FIELDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmp_valid_i  (cmp_valid_i),
  .cmp_field_i  (cmp_field_i),
  .rec_valid_i  (rec_valid_i),
  .rec_result_i (rec_result_i),
  .ovf_i        (ovf_i),
  .so_clear_i   (so_clear_i),
  .so_o         (so_o),
  .cr_o         (cr_o)
);

// File: tb/cr_unit_bench.sv
module cr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_valid_i = 0, cmp_signed_i = 0, cmp_use_imm_i = 0;
  logic [2:0]  cmp_field_i = '0;
  logic [31:0] cmp_a_i = '0, cmp_b_i = '0;
  logic [15:0] cmp_imm_i = '0;
  logic        rec_valid_i = 0;
  logic [31:0] rec_result_i = '0;
  logic        ovf_i = 0, so_clear_i = 0;
  logic        so_o;
  logic [31:0] cr_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] cr_exp = '0;
  logic        so_exp = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cr_unit u_cr_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cmp_model(input logic [31:0] a, input logic [31:0] b,
                                          input logic sgn, input logic so);
    logic lt, gt, eq;
    eq = (a == b);
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    gt = !lt && !eq;
    return {so, eq, gt, lt};
  endfunction

  task automatic op(input logic cv, input logic sg, input logic ui, input logic [2:0] fld,
                    input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                    input logic rv, input logic [31:0] res, input logic ov, input logic cl,
                    input string tag);
    logic [31:0] bv;
    @(negedge clk_i);
    cmp_valid_i = cv; cmp_signed_i = sg; cmp_use_imm_i = ui; cmp_field_i = fld;
    cmp_a_i = a; cmp_b_i = b; cmp_imm_i = imm;
    rec_valid_i = rv; rec_result_i = res; ovf_i = ov; so_clear_i = cl;
    #1 chk("R11 pre-edge", cr_o, cr_exp);
    @(posedge clk_i); #1;
    cmp_valid_i = 0; rec_valid_i = 0; ovf_i = 0; so_clear_i = 0;
    so_exp = (so_exp & ~cl) | ov;
    if (cv) begin
      bv = ui ? (sg ? {{16{imm[15]}}, imm} : {16'h0, imm}) : b;
      cr_exp[fld*4 +: 4] = cmp_model(a, bv, sg, so_exp);
    end else if (rv) begin
      cr_exp[3:0] = {so_exp, res == 0, res != 0 && !res[31], res[31]};
    end
    chk(tag, cr_o, cr_exp);
    chk({tag, " so"}, {31'b0, so_o}, {31'b0, so_exp});
  endtask

  task automatic cmp_rr(input logic sg, input logic [2:0] f, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    op(1, sg, 0, f, a, b, 16'h0, 0, 32'h0, 0, 0, tag);
  endtask

  task automatic cmp_ri(input logic sg, input logic [2:0] f, input logic [31:0] a,
                        input logic [15:0] imm, input string tag);
    op(1, sg, 1, f, a, 32'hDEAD_BEEF, imm, 0, 32'h0, 0, 0, tag);
  endtask

  task automatic rec(input logic [31:0] r, input logic ov, input string tag);
    op(0, 0, 0, 3'd0, 32'h0, 32'h0, 16'h0, 1, r, ov, 0, tag);
  endtask

  task automatic t_reset;
    chk("R10 reset cr", cr_o, 32'h0);
    chk("R10 reset so", {31'b0, so_o}, 32'h0);
  endtask

  task automatic t_signed;
    cmp_rr(1, 3'd1, 32'd5, 32'd3, "R1 gt");
    chk("R1 gt bits", {28'b0, cr_o[7:4]}, 32'h2);
    cmp_rr(1, 3'd1, 32'd3, 32'd5, "R1 lt");
    cmp_rr(1, 3'd2, 32'd7, 32'd7, "R1 eq");
    chk("R1 eq bits", {28'b0, cr_o[11:8]}, 32'h4);
    cmp_rr(1, 3'd3, 32'h8000_0000, 32'h7FFF_FFFF, "R1 min<max");
    cmp_rr(1, 3'd4, 32'h0, 32'hFFFF_FFFF, "R2 signed 0>-1");
    chk("R2 signed gt bit", {28'b0, cr_o[19:16]}, 32'h2);
  endtask

  task automatic t_unsigned;
    cmp_rr(0, 3'd4, 32'h0, 32'hFFFF_FFFF, "R2 unsigned 0<max");
    chk("R2 unsigned lt bit", {28'b0, cr_o[19:16]}, 32'h1);
    cmp_rr(0, 3'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R2 unsigned big");
  endtask

  task automatic t_imm;
    cmp_ri(1, 3'd6, 32'h0, 16'hFFFF, "R3 signed imm -1");
    chk("R3 signed imm bits", {28'b0, cr_o[27:24]}, 32'h2);
    cmp_ri(0, 3'd6, 32'h0, 16'hFFFF, "R3 unsigned imm");
    chk("R3 unsigned imm bits", {28'b0, cr_o[27:24]}, 32'h1);
    cmp_ri(1, 3'd7, 32'hFFFF_FFFF, 16'hFFFF, "R3 signed ext eq");
    cmp_ri(0, 3'd7, 32'h0000_FFFF, 16'hFFFF, "R3 zero ext eq");
    cmp_ri(0, 3'd7, 32'hFFFF_FFFF, 16'hFFFF, "R3 zero ext gt");
  endtask

  task automatic t_fields;
    for (int k = 0; k < 8; k++)
      cmp_rr(1, 3'(k), 32'(k), 32'd3, $sformatf("R4 field %0d", k));
  endtask

  task automatic t_record;
    rec(32'h0, 0, "R5 zero");
    chk("R5 eq bits", {28'b0, cr_o[3:0]}, 32'h4);
    rec(32'h0000_1234, 0, "R5 positive");
    rec(32'hFFFF_0000, 0, "R5 negative");
    rec(32'h8000_0000, 0, "R6 logical sign");
    chk("R6 logical lt", {28'b0, cr_o[3:0]}, 32'h1);
  endtask

  task automatic t_overflow;
    // 0x40000000 + 0x40000000 wraps to 0x80000000
    rec(32'h8000_0000, 1, "R6 overflow wrap");
    chk("R6 lt+so", {28'b0, cr_o[3:0]}, 32'h9);
  endtask

  task automatic t_sticky;
    op(0, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R8 hold idle");
    cmp_rr(0, 3'd2, 32'd1, 32'd1, "R7 so copied");
    chk("R7 so bit", {31'b0, cr_o[11]}, 32'h1);
    op(1, 0, 0, 3'd2, 32'd1, 32'd1, 0, 0, 0, 0, 1, "R7 clear same cycle");
    chk("R7 so bit cleared", {31'b0, cr_o[11]}, 32'h0);
    op(0, 0, 0, 3'd0, 0, 0, 0, 0, 0, 1, 1, "R8 ovf wins clear");
    op(0, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R8 clear");
    op(1, 1, 0, 3'd5, 32'd9, 32'd2, 0, 0, 0, 1, 0, "R7 ovf same cycle");
    chk("R7 so bit set", {31'b0, cr_o[23]}, 32'h1);
  endtask

  task automatic t_collision;
    logic [3:0] f0;
    rec(32'h0, 0, "R9 prime field0");
    f0 = cr_o[3:0];
    op(1, 0, 0, 3'd3, 32'd1, 32'd2, 0, 1, 32'hFFFF_FFFF, 0, 0, "R9 cmp wins");
    chk("R9 field0 kept", {28'b0, cr_o[3:0]}, {28'b0, f0});
    op(0, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    t_signed();
    t_unsigned();
    t_imm();
    t_fields();
    t_record();
    t_overflow();
    t_sticky();
    t_collision();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule